// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block sits in the decode stage of a five-stage in-order pipeline and settles conditional branches and jumps there rather than in the memory stage. A zero or equality test on the already-forwarded operand values decides the direction. A dedicated adder forms the taken target from the sequential PC plus the scaled, sign-extended offset. Fetch always continues on the sequential path, which is a not-taken guess. When a branch or jump is taken, the block steers the fetch PC to the target and raises a flush that clears the valid bit of the IF/ID register. The one instruction fetched down the wrong path then retires as a bubble, so a taken transfer costs a single cycle.

The resolver is combinational. Its outputs feed the PC register mux and the IF/ID valid bit in the same cycle. Discarding the wrong-path instruction is safe because that instruction has not yet reached the memory or writeback stage, where architected state changes. When a load-use stall is raised in the same cycle as a taken branch, the stall wins. The branch stays in decode until the stall clears and redirects only then.

Top module: `br_resolve`

## Requirements
- R1: Opcode 6'b000100 (bits 31:26) is taken when the rs value equals the rt value. Its target is decode PC + 4 + (sign-extended bits 15:0 shifted left by 2).
- R2: Opcode 6'b000101 is taken when the rs value differs from the rt value, with the same target rule as R1.
- R3: Opcode 6'b000110 is taken when the rs value is zero, and opcode 6'b000111 is taken when it is non-zero. The rt value has no effect on either.
- R4: Opcode 6'b000010 is an unconditional jump. Its target is {bits 31:28 of decode PC + 4, bits 25:0 of the instruction, 2'b00}.
- R5: With no stall, and with an untaken branch or any other opcode in a valid decode slot: redirect_o = 0, flush_o = 0 and next_pc_o = if_pc_i + 4.
- R6: A taken branch or jump with no stall sets redirect_o = 1, flush_o = 1 and next_pc_o = target, all in the same cycle. This gives a one-slot penalty.
- R7: While ld_stall_i = 1, redirect_o = 0 and flush_o = 0 whatever the instruction, and next_pc_o = if_pc_i so that fetch holds. The redirect happens in the first cycle after the stall drops.
- R8: When id_valid_i = 0, the instruction bits have no effect: the outputs are those of R5.
- R9: The offset is sign-extended from bit 15. Offset 0x8000 moves the target back by 0x20000 bytes, and offset 0x7FFF moves it forward by 0x1FFFC bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid_i | input | 1 | Decode slot holds a live instruction |
| id_instr_i | input | 32 | Instruction in decode |
| id_pc_i | input | XLEN | PC of the decode instruction |
| rs_val_i | input | XLEN | Forwarded value of the first source register |
| rt_val_i | input | XLEN | Forwarded value of the second source register |
| if_pc_i | input | XLEN | PC currently in fetch |
| ld_stall_i | input | 1 | Load-use stall holding decode |
| redirect_o | output | 1 | Select target as the next fetch PC |
| next_pc_o | output | XLEN | Next fetch PC |
| flush_o | output | 1 | Clear the IF/ID valid bit |

## Verification
The assertions take for granted that both PCs are word-aligned. They also assume that the forwarding network has already placed the correct operand values on rs_val_i and rt_val_i in the cycle the branch sits in decode. The stimulus uses only multiples of four for id_pc_i and if_pc_i, with if_pc_i one word past id_pc_i. It holds each operand pair steady for a full cycle. The stall case is driven by repeating the same branch first with the stall raised and then with it lowered, which follows how a held decode stage looks at this block's ports.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam logic [5:0] OP_JMP = 6'b000010;
  localparam logic [5:0] OP_BEQ = 6'b000100;
  localparam logic [5:0] OP_BNE = 6'b000101;
  localparam logic [5:0] OP_BEZ = 6'b000110;
  localparam logic [5:0] OP_BNZ = 6'b000111;

  localparam int unsigned OFF_W = 16;
  localparam int unsigned JT_W  = 26;

  typedef enum logic [2:0] {
    K_NONE, K_EQ, K_NE, K_EZ, K_NZ, K_JMP
  } br_kind_e;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
(
  input  logic                valid_i,
  input  logic [31:0]         instr_i,
  output br_kind_e            kind_o,
  output logic [OFF_W-1:0]    off_o,
  output logic [JT_W-1:0]     jt_o
);
  always_comb begin
    kind_o = K_NONE;
    if (valid_i) begin
      unique case (instr_i[31:26])
        OP_BEQ:  kind_o = K_EQ;
        OP_BNE:  kind_o = K_NE;
        OP_BEZ:  kind_o = K_EZ;
        OP_BNZ:  kind_o = K_NZ;
        OP_JMP:  kind_o = K_JMP;
        default: kind_o = K_NONE;
      endcase
    end
  end

  assign off_o = instr_i[OFF_W-1:0];
  assign jt_o  = instr_i[JT_W-1:0];
endmodule

// File: rtl/br_cond.sv
module br_cond
  import br_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  br_kind_e          kind_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic              taken_o
);
  logic eq, a_zero;
  assign eq     = (a_i == b_i);
  assign a_zero = (a_i == '0);

  always_comb begin
    unique case (kind_i)
      K_EQ:    taken_o = eq;
      K_NE:    taken_o = !eq;
      K_EZ:    taken_o = a_zero;
      K_NZ:    taken_o = !a_zero;
      K_JMP:   taken_o = 1'b1;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target
  import br_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]   pc_i,
  input  br_kind_e          kind_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [JT_W-1:0]   jt_i,
  output logic [XLEN-1:0]   target_o
);
  localparam int unsigned SH_W  = OFF_W + 2;
  localparam int unsigned JLO_W = JT_W + 2;

  logic [XLEN-1:0]  seq_pc, br_tgt, jmp_tgt;
  logic [JLO_W-1:0] jlo;

  assign seq_pc = pc_i + XLEN'(4);
  assign br_tgt = seq_pc + {{(XLEN-SH_W){off_i[OFF_W-1]}}, off_i, 2'b00};
  assign jlo    = {jt_i, 2'b00};

  // Jump keeps the region bits of the sequential PC when the PC is wider
  generate
    if (XLEN > JLO_W) begin : g_region
      assign jmp_tgt = {seq_pc[XLEN-1:JLO_W], jlo};
    end else begin : g_flat
      assign jmp_tgt = jlo[XLEN-1:0];
    end
  endgenerate

  assign target_o = (kind_i == K_JMP) ? jmp_tgt : br_tgt;
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              id_valid_i,
  input  logic [31:0]       id_instr_i,
  input  logic [XLEN-1:0]   id_pc_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic [XLEN-1:0]   if_pc_i,
  input  logic              ld_stall_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              flush_o
);
  br_kind_e         kind;
  logic [OFF_W-1:0] off;
  logic [JT_W-1:0]  jt;
  logic             taken;
  logic [XLEN-1:0]  target;

  br_decode u_dec (
    .valid_i (id_valid_i),
    .instr_i (id_instr_i),
    .kind_o  (kind),
    .off_o   (off),
    .jt_o    (jt)
  );

  br_cond #(.XLEN(XLEN)) u_cond (
    .kind_i  (kind),
    .a_i     (rs_val_i),
    .b_i     (rt_val_i),
    .taken_o (taken)
  );

  br_target #(.XLEN(XLEN)) u_tgt (
    .pc_i     (id_pc_i),
    .kind_i   (kind),
    .off_i    (off),
    .jt_i     (jt),
    .target_o (target)
  );

  // Stall wins: branch waits in decode for its operand
  assign redirect_o = taken && !ld_stall_i;
  assign flush_o    = redirect_o;

  always_comb begin
    if (redirect_o)      next_pc_o = target;
    else if (ld_stall_i) next_pc_o = if_pc_i;
    else                 next_pc_o = if_pc_i + XLEN'(4);
  end
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic              id_valid_i,
  input logic [31:0]       id_instr_i,
  input logic [XLEN-1:0]   id_pc_i,
  input logic [XLEN-1:0]   rs_val_i,
  input logic [XLEN-1:0]   rt_val_i,
  input logic [XLEN-1:0]   if_pc_i,
  input logic              ld_stall_i,
  input logic              redirect_o,
  input logic [XLEN-1:0]   next_pc_o,
  input logic              flush_o
);
  always_comb begin
    AST_FLUSH_WITH_REDIRECT: assert (flush_o == redirect_o); // R6
    if (ld_stall_i) begin
      AST_STALL_NO_REDIRECT: assert (!redirect_o && !flush_o); // R7
      AST_STALL_HOLDS_FETCH: assert (next_pc_o == if_pc_i);    // R7
    end
    if (!id_valid_i) begin
      AST_INVALID_QUIET: assert (!redirect_o && next_pc_o == if_pc_i + XLEN'(4) || ld_stall_i); // R8
    end
    if (redirect_o && id_pc_i[1:0] == 2'b00) begin
      AST_TARGET_ALIGNED: assert (next_pc_o[1:0] == 2'b00); // R1
    end
  end
endmodule

bind br_resolve br_resolve_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_br_resolve.sv
module sim_br_resolve;
  localparam int unsigned XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            id_valid;
  logic [31:0]     id_instr;
  logic [XLEN-1:0] id_pc, rs_val, rt_val, if_pc;
  logic            ld_stall;
  logic            redirect, flush;
  logic [XLEN-1:0] next_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic            redir;
    logic [XLEN-1:0] pc;
    logic            fl;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  br_resolve #(.XLEN(XLEN)) u0 (
    .id_valid_i (id_valid), .id_instr_i (id_instr), .id_pc_i (id_pc),
    .rs_val_i (rs_val), .rt_val_i (rt_val), .if_pc_i (if_pc),
    .ld_stall_i (ld_stall), .redirect_o (redirect), .next_pc_o (next_pc),
    .flush_o (flush)
  );

  function automatic logic [31:0] mk(logic [5:0] op, logic [25:0] low);
    return {op, low};
  endfunction

  // Reference model written from the requirements
  function automatic exp_t model(logic v, logic [31:0] ins, logic [XLEN-1:0] pc,
                                 logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                                 logic [XLEN-1:0] fpc, logic st);
    exp_t e;
    logic tk;
    logic [XLEN-1:0] p4, tgt;
    p4  = pc + 32'd4;
    tgt = p4 + {{14{ins[15]}}, ins[15:0], 2'b00};
    tk  = 1'b0;
    case (ins[31:26])
      6'b000100: tk = (a == b);
      6'b000101: tk = (a != b);
      6'b000110: tk = (a == 0);
      6'b000111: tk = (a != 0);
      6'b000010: begin tk = 1'b1; tgt = {p4[31:28], ins[25:0], 2'b00}; end
      default:   tk = 1'b0;
    endcase
    tk = tk && v && !st;
    e.redir = tk;
    e.fl    = tk;
    e.pc    = tk ? tgt : (st ? fpc : fpc + 32'd4);
    return e;
  endfunction

  task automatic drive(string tag, logic v, logic [31:0] ins, logic [XLEN-1:0] pc,
                       logic [XLEN-1:0] a, logic [XLEN-1:0] b, logic st);
    @(posedge clk);
    #1;
    id_valid = v; id_instr = ins; id_pc = pc; rs_val = a; rt_val = b;
    if_pc = pc + 32'd4; ld_stall = st;
    exp_q.push_back(model(v, ins, pc, a, b, pc + 32'd4, st));
    tag_q.push_back(tag);
  endtask

  // Monitor: compares away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (redirect !== e.redir || next_pc !== e.pc || flush !== e.fl) begin
          errors++;
          $display("FAIL %s: got redir=%0b pc=%h flush=%0b, exp redir=%0b pc=%h flush=%0b",
                   t, redirect, next_pc, flush, e.redir, e.pc, e.fl);
        end
      end
    end
  end

  initial begin
    id_valid = 0; id_instr = '0; id_pc = 32'h1000; rs_val = '0; rt_val = '0;
    if_pc = 32'h1004; ld_stall = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset/idle state
    drive("R8 idle", 0, '0, 32'h1000, 0, 0, 0);
    drive("R1 beq taken", 1, mk(6'b000100, {10'd0, 16'h0003}), 32'h1000, 5, 5, 0);
    drive("R5 beq untaken", 1, mk(6'b000100, {10'd0, 16'h0003}), 32'h1000, 5, 6, 0);
    drive("R2 bne taken back", 1, mk(6'b000101, {10'd0, 16'hFFFF}), 32'h1000, 1, 2, 0);
    drive("R2 bne untaken", 1, mk(6'b000101, {10'd0, 16'hFFFF}), 32'h1000, 9, 9, 0);
    drive("R3 bez taken rt ignored", 1, mk(6'b000110, {10'd0, 16'h0010}), 32'h2000, 0, 5, 0);
    drive("R3 bez untaken", 1, mk(6'b000110, {10'd0, 16'h0010}), 32'h2000, 1, 0, 0);
    drive("R3 bnz taken", 1, mk(6'b000111, {10'd0, 16'h0020}), 32'h2000, 7, 7, 0);
    drive("R3 bnz untaken", 1, mk(6'b000111, {10'd0, 16'h0020}), 32'h2000, 0, 3, 0);
    drive("R4 jump", 1, mk(6'b000010, 26'h0000123), 32'h3000_0100, 0, 0, 0);
    drive("R5 other opcode", 1, mk(6'b000000, 26'h0), 32'h1000, 4, 4, 0);
    drive("R7 stall holds branch", 1, mk(6'b000100, {10'd0, 16'h0008}), 32'h5000, 3, 3, 1);
    drive("R7 stall holds jump", 1, mk(6'b000010, 26'h0000040), 32'h5000, 0, 0, 1);
    drive("R6 redirect after stall", 1, mk(6'b000100, {10'd0, 16'h0008}), 32'h5000, 3, 3, 0);
    drive("R8 invalid beq", 0, mk(6'b000100, {10'd0, 16'h0008}), 32'h5000, 3, 3, 0);
    drive("R8 invalid jump", 0, mk(6'b000010, 26'h0000040), 32'h5000, 0, 0, 0);
    drive("R9 min offset", 1, mk(6'b000100, {10'd0, 16'h8000}), 32'h0004_0000, 0, 0, 0);
    drive("R9 max offset", 1, mk(6'b000100, {10'd0, 16'h7FFF}), 32'h0004_0000, 0, 0, 0);
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 10000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, exp completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule